// File: doc/BRIEF.md
# Two-Wire Sector-Programmed Memory Slave

This block is the device side of a two-wire serial bus, in front of a small non-volatile memory model. It watches a bus clock and a data line, recognises start and stop conditions, and answers to one configurable 7-bit device address. The lowest bit of the device byte selects the direction: 0 for write and 1 for read. It drives the data line only through an open-drain pull-down enable. A write transaction carries two address bytes and then the data for one 32-byte sector. Data bytes land in a sector buffer, and only the five low address bits advance between bytes, so a write that starts mid-sector wraps around inside that sector.

A stop after at least one data byte starts a program cycle whose length is a parameter counted in system clocks. For that whole cycle the device is deaf: it acknowledges nothing, decodes nothing and does not touch the bus. At the end of the cycle the buffered sector is committed to the array. A master can therefore poll for completion by sending the device address until it is acknowledged. If the byte count before the stop was not exactly 32, a sticky sector-error output is raised.

Three read forms are available. A current-address read uses the internal pointer. A random read uses an address-only write, then a repeated start and a read. A sequential read keeps going while the master acknowledges, with the pointer advancing across the full address range. A read ends when the master leaves the ninth clock unacknowledged and sends a stop, or when it sends a stop during that ninth clock.

Top module: `sflash_slave`

## Requirements
- R1: After reset the pull-down enable is low, the sector-error output is low, and every array byte reads as 8'hFF.
- R2: A start condition (data falling while the bus clock is high) begins a device byte. The device pulls data low on the ninth clock only when bits 7..1 of that byte equal DEV_ADDR. For any other address it never pulls data low until the next start.
- R3: After a matching write-direction device byte, two address bytes follow, the high byte first. The pointer takes the low ADDR_W bits of the 16-bit value. Each address byte is acknowledged.
- R4: Each acknowledged data byte is stored at the pointer's low 5 bits within the sector fixed by the upper pointer bits. Only the low 5 bits then increment, wrapping from 31 to 0.
- R5: A stop after one or more data bytes starts a program cycle of PROG_CYCLES clocks. The buffered sector becomes readable only after that cycle ends.
- R6: While the program cycle runs, the device acknowledges nothing, including its own address, and bus traffic changes no stored byte.
- R7: At the stop that starts a program cycle, the sector-error output becomes 1 if the data byte count was not 32, and 0 if it was exactly 32. It changes at no other time.
- R8: A random read (address-only write, repeated start, read-direction device byte) returns the byte at the written address.
- R9: A current-address read returns the byte one past the last byte read or written.
- R10: In a read, a master acknowledge on the ninth clock advances the full address by one and starts the next byte, so reads cross sector boundaries.
- R11: A read ends either on a master no-acknowledge followed by a stop, or on a stop issued during the ninth clock. In both cases the pull-down is released and the pointer sits one past the last byte sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | When 1, the device pulls the data line low |
| sector_err_o | output | 1 | Sticky flag: the last programmed sector received a byte count other than 32 |

## Verification
If the bit-phase counter slips, the fault appears on the ninth clock of the very next byte: the acknowledge goes missing or lands a bit early, and the master sees it as a NACK or as a corrupt byte. A pointer that wraps wrongly is not visible until the program cycle has committed the sector. Random reads of both sector ends then show the misplacement one busy period after the stop. A busy timer that is too short or never clears shows up as an early or missing acknowledge to address polling. The bench measures that polling latency in clocks against PROG_CYCLES.

// File: rtl/sflash_pkg.sv
// Shared types for the two-wire sector-programmed memory slave.
package sflash_pkg;
    // Transfer phase of the bus engine.
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a start condition
        ST_DEV,     // receiving the device byte
        ST_AHI,     // receiving the high address byte
        ST_ALO,     // receiving the low address byte
        ST_WDAT,    // receiving sector data
        ST_RDAT     // sending read data
    } bus_st_t;
endpackage

// File: rtl/sflash_bus_sync.sv
// Two-flop synchroniser for the bus clock and data lines, plus event decode.
// Assumes the bus is far slower than clk, so each line holds for several clocks.
// Start: data falls while clock high. Stop: data rises while clock high.
module sflash_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q;

    // Synchronise both lines and keep one cycle of history; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    assign sda_o   = sda_ff[1];
    assign start_o = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
    assign stop_o  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
    assign rise_o  = scl_ff[1] & ~scl_q;
    assign fall_o  = ~scl_ff[1] & scl_q;
endmodule

// File: rtl/sflash_prog_timer.sv
// Program-cycle timer: a go pulse while idle holds busy for PROG_CYCLES clocks.
// done_o marks the last busy cycle, when the sector is committed.
module sflash_prog_timer #(
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Load the count on go and run it down to zero while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt    <= '0;
        end else if (!busy_o && go_i) begin
            busy_o <= 1'b1;
            cnt    <= CNT_W'(PROG_CYCLES - 1);
        end else if (busy_o) begin
            if (cnt == '0) busy_o <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign done_o = busy_o && (cnt == '0);

    // R5
    prog_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: rtl/sflash_store.sv
// Sector buffer and byte array. Buffer bytes are written one at a time.
// A commit copies the whole buffer into the sector picked by commit_base.
// The array resets to the erased value 8'hFF.
module sflash_store #(
    parameter int ADDR_W = 8,
    parameter int SEC_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    buf_we_i,
    input  logic [SEC_W-1:0]        buf_idx_i,
    input  logic [7:0]              buf_data_i,
    input  logic                    commit_i,
    input  logic [ADDR_W-SEC_W-1:0] commit_base_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic [7:0]              rd_data_o
);
    localparam int SEC_BYTES = 1 << SEC_W;
    localparam int MEM_BYTES = 1 << ADDR_W;

    logic [7:0] sbuf [SEC_BYTES];
    logic [7:0] mem  [MEM_BYTES];

    // Capture incoming data bytes into the sector buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEC_BYTES; i++) sbuf[i] <= 8'hFF;
        end else if (buf_we_i) begin
            sbuf[buf_idx_i] <= buf_data_i;
        end
    end

    // Commit the full buffer into the array at the end of the program cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (commit_i) begin
            for (int i = 0; i < SEC_BYTES; i++)
                mem[{commit_base_i, SEC_W'(i)}] <= sbuf[i];
        end
    end

    assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/sflash_slave.sv
// Two-wire memory slave: device/address decode, sector write, busy period, reads.
// Bit phase: bitcnt counts bus-clock rises 0..8 within a byte; 9 marks the
// ninth clock. Acknowledge and read bits are driven after falls.
// Assumes the bus clock is at least ~8 system clocks per half period.
module sflash_slave
    import sflash_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 8,
    parameter int         SEC_W       = 5,
    parameter int         PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o,
    output logic sector_err_o
);
    localparam int SEC_BYTES = 1 << SEC_W;
    localparam int HI_W      = ADDR_W - SEC_W;
    localparam int WC_W      = SEC_W + 2;

    logic sda_s, start, stop, rise, fall;
    logic busy, done, prog_go, buf_we;
    logic [7:0] rd_data;

    bus_st_t          st;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg, out_sh, ahi;
    logic [ADDR_W-1:0] ptr;
    logic [HI_W-1:0]  base;
    logic [WC_W-1:0]  wcount;
    logic             mack, rd_first;
    logic [15:0]      full_addr;
    logic             unused_hi;

    sflash_bus_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
    );

    sflash_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .go_i(prog_go), .busy_o(busy), .done_o(done)
    );

    sflash_store #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .buf_we_i(buf_we), .buf_idx_i(ptr[SEC_W-1:0]), .buf_data_i(shreg),
        .commit_i(done), .commit_base_i(base),
        .rd_addr_i(ptr), .rd_data_o(rd_data)
    );

    assign full_addr = {ahi, shreg};
    assign unused_hi = ^full_addr;
    assign buf_we    = !busy && !start && !stop && fall
                       && (st == ST_WDAT) && (bitcnt == 4'd8);
    assign prog_go   = !busy && stop && (st == ST_WDAT) && (wcount != '0);

    // Bus engine: phase tracking, acknowledge, pointer and read shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; bitcnt <= '0; shreg <= '0; out_sh <= '0; ahi <= '0;
            ptr <= '0; base <= '0; wcount <= '0; mack <= 1'b0; rd_first <= 1'b0;
            sda_pull_o <= 1'b0;
        end else if (busy) begin
            st <= ST_IDLE; bitcnt <= '0; sda_pull_o <= 1'b0;
        end else if (start) begin
            st <= ST_DEV; bitcnt <= '0; sda_pull_o <= 1'b0;
        end else if (stop) begin
            st <= ST_IDLE; bitcnt <= '0; sda_pull_o <= 1'b0;
        end else if (st != ST_IDLE) begin
            if (rise) begin
                if (bitcnt < 4'd8) begin
                    shreg  <= {shreg[6:0], sda_s};
                    bitcnt <= bitcnt + 1'b1;
                end else if (bitcnt == 4'd8) begin
                    mack   <= ~sda_s;
                    bitcnt <= 4'd9;
                end
            end else if (fall) begin
                if (bitcnt == 4'd8) begin
                    sda_pull_o <= 1'b0;
                    case (st)
                        ST_DEV: begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                sda_pull_o <= 1'b1;
                                st         <= shreg[0] ? ST_RDAT : ST_AHI;
                                rd_first   <= 1'b1;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_AHI: begin
                            ahi <= shreg; sda_pull_o <= 1'b1; st <= ST_ALO;
                        end
                        ST_ALO: begin
                            ptr    <= full_addr[ADDR_W-1:0];
                            base   <= full_addr[ADDR_W-1:SEC_W];
                            wcount <= '0; sda_pull_o <= 1'b1; st <= ST_WDAT;
                        end
                        ST_WDAT: begin
                            sda_pull_o      <= 1'b1;
                            ptr[SEC_W-1:0]  <= ptr[SEC_W-1:0] + 1'b1;
                            if (wcount != '1) wcount <= wcount + 1'b1;
                        end
                        default: ;
                    endcase
                end else if (bitcnt == 4'd9) begin
                    bitcnt     <= '0;
                    sda_pull_o <= 1'b0;
                    if (st == ST_RDAT) begin
                        if (rd_first || mack) begin
                            out_sh     <= rd_data;
                            sda_pull_o <= ~rd_data[7];
                            ptr        <= ptr + 1'b1;
                            rd_first   <= 1'b0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end else if (st == ST_RDAT && bitcnt != 4'd0) begin
                    out_sh     <= out_sh << 1;
                    sda_pull_o <= ~out_sh[6];
                end
            end
        end
    end

    // Sticky sector-error flag, updated only at a stop that starts programming.
    always_ff @(posedge clk) begin
        if (!rst_n)       sector_err_o <= 1'b0;
        else if (prog_go) sector_err_o <= (wcount != WC_W'(SEC_BYTES));
    end

    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    // R4
    sector_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WDAT && $past(st == ST_WDAT)) |-> $stable(ptr[ADDR_W-1:SEC_W]));

    // R7
    err_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sector_err_o) |-> $past(stop));

    // R10
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RDAT && $past(st == ST_RDAT) && !$stable(ptr)) |-> $past(fall));
endmodule

// File: tb/sflash_slave_bench.sv
// Bench: bit-banged bus master, table of random reads, then directed cases.
module sflash_slave_bench;
    localparam int PROG = 1500;
    localparam int H    = 8;
    localparam logic [7:0] DEVW = 8'hA0;
    localparam logic [7:0] DEVR = 8'hA1;
    // {address, expected byte} after writing 32 bytes 8'h10+k from 8'h45
    localparam logic [15:0] RD_VEC [7] = '{
        {8'h45, 8'h10}, {8'h5F, 8'h2A}, {8'h40, 8'h2B}, {8'h44, 8'h2F},
        {8'h50, 8'h1B}, {8'h60, 8'hFF}, {8'h33, 8'hFF}
    };

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic sda_pull, sec_err, sda_bus;
    int   checks = 0, errors = 0, cyc = 0;
    bit   done_flag = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign sda_bus = sda_m & ~sda_pull;

    sflash_slave #(.PROG_CYCLES(PROG)) u_sflash_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .sector_err_o(sec_err)
    );

    task automatic wt(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(2);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H); scl = 1'b1; wt(H); scl = 1'b0;
        end
        sda_m = 1'b1; wt(H); scl = 1'b1; wt(H/2); ack = ~sda_bus; wt(H/2); scl = 1'b0;
    endtask

    task automatic recv_bits(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H); scl = 1'b1; wt(H/2); b[i] = sda_bus; wt(H/2); scl = 1'b0;
        end
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        recv_bits(b);
        sda_m = ~give_ack; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(2); sda_m = 1'b1;
    endtask

    task automatic set_addr(input logic [7:0] a, output int nacks);
        logic ack;
        nacks = 0;
        bus_start;
        send_byte(DEVW, ack); if (!ack) nacks++;
        send_byte(8'h00, ack); if (!ack) nacks++;
        send_byte(a, ack);     if (!ack) nacks++;
    endtask

    task automatic wr_bytes(input logic [7:0] a, input int n, input logic [7:0] v0,
                            output int nacks);
        logic ack;
        set_addr(a, nacks);
        for (int k = 0; k < n; k++) begin
            send_byte(v0 + 8'(k), ack); if (!ack) nacks++;
        end
        bus_stop;
    endtask

    task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
        int  n;
        logic ack;
        set_addr(a, n);
        bus_start; send_byte(DEVR, ack); recv_byte(1'b0, d); bus_stop;
    endtask

    task automatic cur_read(output logic [7:0] d);
        logic ack;
        bus_start; send_byte(DEVR, ack); recv_byte(1'b0, d); bus_stop;
    endtask

    task automatic poll(output logic ack);
        bus_start; send_byte(DEVW, ack); bus_stop;
    endtask

    task automatic wait_ready(output int polls);
        logic ack = 1'b0;
        polls = 0;
        while (!ack && polls < 40) begin poll(ack); polls++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2, d3;
        logic ack;
        int n, polls, t0;
        wt(5); rst_n = 1'b1; wt(3);
        // R1 reset state
        chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
        chk(sec_err == 1'b0, "R1 err after reset", sec_err, 0);
        // R2 foreign device address is not acknowledged
        bus_start; send_byte(8'hA2, ack); bus_stop;
        chk(ack == 1'b0, "R2 foreign address", ack, 0);
        // R1 erased array, R8 random read
        rand_read(8'h33, d);
        chk(d == 8'hFF, "R1 erased byte", d, 8'hFF);
        // R3 R4 full sector write starting mid-sector
        wr_bytes(8'h45, 32, 8'h10, n); t0 = cyc;
        chk(n == 0, "R3 address and data acks", n, 0);
        chk(sec_err == 1'b0, "R7 exact 32 bytes", sec_err, 0);
        // R6 busy: no ack, writes ignored
        poll(ack);
        chk(ack == 1'b0, "R6 busy poll", ack, 0);
        wr_bytes(8'h60, 1, 8'h77, n);
        chk(n == 4, "R6 busy write nacked", n, 4);
        // R5 busy length
        wait_ready(polls);
        chk(cyc - t0 >= PROG - H && cyc - t0 <= PROG + 600, "R5 program length", cyc - t0, PROG);
        // Table walk: R4 wrap, R5 commit, R6 ignored write, R8 random read
        foreach (RD_VEC[i]) begin
            rand_read(RD_VEC[i][15:8], d);
            chk(d == RD_VEC[i][7:0], "R4/R8 table read", d, RD_VEC[i][7:0]);
        end
        // R9 current address after reading 8'h45
        rand_read(8'h45, d);
        cur_read(d);
        chk(d == 8'h11, "R9 current address", d, 8'h11);
        // R10 sequential read across sector edge
        set_addr(8'h5E, n);
        bus_start; send_byte(DEVR, ack);
        recv_byte(1'b1, d); recv_byte(1'b1, d2); recv_byte(1'b0, d3); bus_stop;
        chk(d == 8'h29, "R10 seq byte0", d, 8'h29);
        chk(d2 == 8'h2A, "R10 seq byte1", d2, 8'h2A);
        chk(d3 == 8'hFF, "R10 seq cross", d3, 8'hFF);
        chk(sda_pull == 1'b0, "R11 release after nack stop", sda_pull, 0);
        // R11 stop during ninth clock
        set_addr(8'h45, n);
        bus_start; send_byte(DEVR, ack); recv_bits(d);
        sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
        chk(d == 8'h10, "R11 byte before stop", d, 8'h10);
        chk(sda_pull == 1'b0, "R11 release after ninth stop", sda_pull, 0);
        cur_read(d);
        chk(d == 8'h11, "R11 pointer after ninth stop", d, 8'h11);
        // R7 short sector write raises error, full write clears it
        wr_bytes(8'h80, 3, 8'h55, n);
        chk(sec_err == 1'b1, "R7 short write", sec_err, 1);
        wait_ready(polls);
        wr_bytes(8'hA0, 32, 8'hC0, n);
        chk(sec_err == 1'b0, "R7 full write clears", sec_err, 0);
        wait_ready(polls);
        rand_read(8'hBF, d);
        chk(d == 8'hDF, "R4 second sector last byte", d, 8'hDF);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule